// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable two-wire bus target that behaves like a small byte-wide serial EEPROM. A fast system clock oversamples the bus clock (SCL) and data (SDA) lines. The block detects start and stop conditions and answers a 7-bit device address. That address carries a fixed 4-bit type code and three bits that must match strap inputs. After a write address, one byte sets the internal word pointer. The bytes that follow are collected into a page buffer. A read address returns bytes from the pointer onward.

The array holds 256 bytes in pages of 8. Write bursts wrap inside their page, and reads walk the whole array. Written bytes reach the array only when a stop condition arrives. If the write-protect input is high at that moment, the bytes are dropped. A committed write starts a timed busy window, sized in system clocks. During that window the target refuses its address, so a controller can poll for completion. SDA is driven only as an open-drain pull-down enable.

Top module: `eeprom_target`

## Requirements
- R1: Out of reset the pull-down is released and every array byte reads 0x00. The pull-down only turns on while SCL is low.
- R2: SDA falling while SCL is high begins a transfer. SDA rising while SCL is high ends it.
- R3: The first byte after a start is answered only if bits 7:4 equal 4'b1010 and bits 3:1 equal the strap inputs. Bit 0 selects read (1) or write (0). Otherwise SDA stays released.
- R4: The target pulls SDA low on the ninth clock after a matching address byte, a word-address byte and each write data byte.
- R5: In a write burst only the low 3 pointer bits advance, so page offset 7 is followed by offset 0 of the same page. More than 8 bytes overwrite the earlier ones.
- R6: Write data reaches the array only at a stop. A start that arrives first discards the pending bytes.
- R7: With write-protect high at the stop, no byte is stored and no busy window starts.
- R8: After a committed write, the address byte is not acknowledged for BUSY_CYCLES clocks. After that it is acknowledged again.
- R9: A random read (word address, repeated start, read address) returns the byte stored at that address.
- R10: Sequential reads advance the pointer across all 256 bytes, and 0xFF is followed by 0x00.
- R11: A read without a word address starts at one past the last byte accessed. After a write, that is one past the last written byte, within its page.
- R12: When the controller does not acknowledge a read byte, the target stops sending and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| strapAddr | input | 3 | Strap bits the device address must match |
| wpIn | input | 1 | Write protect, high blocks array updates |
| sdaPullLow | output | 1 | Open-drain enable, high pulls SDA low |

## Verification
The hardest situations to reach are the busy window and a repeated start that arrives while write data is still pending. Both depend on when the controller acts relative to an internal event, not on the byte values. The bench shrinks the busy length through the parameter. It polls the address right after a stop, then polls again once the window has closed. It also issues a repeated start immediately after a data byte's acknowledge and reads the location back. A behavioural array model with its own pointer predicts every acknowledge and read byte. A per-clock monitor checks that the pull-down never moves while SCL is high.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEVACK, S_WADDR, S_WADDRACK,
    S_WDATA, S_WDATAACK, S_RDATA, S_RACK
  } busState_e;

  typedef struct packed {
    logic discard;
    logic loadPtr;
    logic bufWrite;
    logic ptrNext;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strapAddr,
  input  logic              busyIn,
  input  logic [BYTE_W-1:0] rdByte,
  output logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         stb,
  output logic              sdaPullLow
);
  logic [1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startDet, stopDet;
  busState_e state;
  logic [3:0] bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic isRead, ctlAck, byteDone, addrHit;

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign byteDone = (bitCnt == 4'd8);
  assign addrHit  = (shReg[7:4] == DEV_TYPE) && (shReg[3:1] == strapAddr) && !busyIn;
  assign rxByte   = shReg;

  always_comb begin
    stb          = '0;
    stb.discard  = startDet;
    stb.commit   = stopDet;
    stb.loadPtr  = (state == S_WADDR) && byteDone && sclFall;
    stb.bufWrite = (state == S_WDATA) && byteDone && sclFall;
    stb.ptrNext  = (state == S_RACK) && sclRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11;
      sclP <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP <= sclS; sdaP <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; bitCnt <= '0; shReg <= '0;
      isRead <= 1'b0; ctlAck <= 1'b0; sdaPullLow <= 1'b0;
    end else if (startDet) begin
      state <= S_DEV; bitCnt <= '0; sdaPullLow <= 1'b0;
    end else if (stopDet) begin
      state <= S_IDLE; sdaPullLow <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_WADDR, S_WDATA: begin
          if (sclRise && !byteDone) begin
            shReg  <= {shReg[BYTE_W-2:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && byteDone) begin
            if (state == S_DEV) begin
              if (addrHit) begin
                sdaPullLow <= 1'b1; isRead <= shReg[0]; state <= S_DEVACK;
              end else state <= S_IDLE;
            end else begin
              sdaPullLow <= 1'b1;
              state <= (state == S_WADDR) ? S_WADDRACK : S_WDATAACK;
            end
          end
        end
        S_DEVACK: if (sclFall) begin
          bitCnt <= '0;
          if (isRead) begin
            shReg <= rdByte; sdaPullLow <= ~rdByte[BYTE_W-1]; state <= S_RDATA;
          end else begin
            sdaPullLow <= 1'b0; state <= S_WADDR;
          end
        end
        S_WADDRACK, S_WDATAACK: if (sclFall) begin
          sdaPullLow <= 1'b0; bitCnt <= '0; state <= S_WDATA;
        end
        S_RDATA: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall) begin
            if (byteDone) begin
              sdaPullLow <= 1'b0; state <= S_RACK;
            end else begin
              shReg <= {shReg[BYTE_W-2:0], 1'b0};
              sdaPullLow <= ~shReg[BYTE_W-2];
            end
          end
        end
        S_RACK: begin
          if (sclRise) ctlAck <= ~sdaS;
          else if (sclFall) begin
            if (ctlAck) begin
              shReg <= rdByte; sdaPullLow <= ~rdByte[BYTE_W-1];
              bitCnt <= '0; state <= S_RDATA;
            end else state <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  // R1: the pull-down is only switched on while the synchronised SCL is low
  assert_pull_scl_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS);
  // R8: no address acknowledge phase is entered while a program cycle runs
  assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEVACK) |-> !busyIn);
  // R12: after a missing controller acknowledge the target goes quiet
  assert_nack_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RACK && sclFall && !ctlAck && !startDet && !stopDet) |=> !sdaPullLow && state == S_IDLE);
endmodule

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              wpIn,
  output logic [BYTE_W-1:0] rdByte,
  output logic              busy
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int CNT_W    = $clog2(BUSY_CYCLES + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pageValid;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0] busyCnt;

  assign rdByte = mem[ptr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_LEN; i++) pageBuf[i] <= '0;
      pageValid <= '0; ptr <= '0; busy <= 1'b0; busyCnt <= '0;
    end else begin
      if (stb.discard) pageValid <= '0;
      else if (stb.loadPtr) ptr <= rxByte[ADDR_W-1:0];
      else if (stb.bufWrite) begin
        pageBuf[ptr[PAGE_W-1:0]]   <= rxByte;
        pageValid[ptr[PAGE_W-1:0]] <= 1'b1;
        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      end else if (stb.ptrNext) ptr <= ptr + 1'b1;
      else if (stb.commit) begin
        if (|pageValid && !wpIn) begin
          for (int i = 0; i < PAGE_LEN; i++)
            if (pageValid[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
          busy <= 1'b1;
          busyCnt <= CNT_W'(BUSY_CYCLES - 1);
        end
        pageValid <= '0;
      end
      if (busy) begin
        if (busyCnt == '0) busy <= 1'b0;
        else busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  // R5: a buffered write byte never moves the page part of the pointer
  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufWrite |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
  // R10: read advance rolls from the top address to zero
  assert_read_roll_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ptrNext && ptr == {ADDR_W{1'b1}}) |=> ptr == '0);
  // R7: a protected stop leaves the program cycle idle
  assert_wp_no_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && wpIn && !busy) |=> !busy);
  // R8: a program cycle only ever starts from a stop
  assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stb.commit));
endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       wpIn,
  output logic       sdaPullLow
);
  dpStrobe_t stb;
  logic [BYTE_W-1:0] rxByte, rdByte;
  logic busy;

  eeprom_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapAddr(strapAddr), .busyIn(busy), .rdByte(rdByte),
    .rxByte(rxByte), .stb(stb), .sdaPullLow(sdaPullLow)
  );

  eeprom_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte),
    .wpIn(wpIn), .rdByte(rdByte), .busy(busy)
  );
endmodule

// File: tb/tb_eeprom_target.sv
module tb_eeprom_target;
  localparam int BUSY = 400;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rstN = 1'b0;
  logic scl = 1'b1, mSda = 1'b1, wp = 1'b0;
  logic sdaPullLow;
  wire  sdaBus = mSda & ~sdaPullLow;

  int checks = 0, fails = 0, glitches = 0;
  bit done = 1'b0;
  logic [7:0] modelMem [256];
  logic [7:0] pend [8];
  bit pendV [8];
  int modelPtr = 0;
  logic [7:0] wq [$];
  logic sclPrevM = 1'b1, pullPrevM = 1'b0;

  eeprom_target #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .strapAddr(STRAP), .wpIn(wp), .sdaPullLow(sdaPullLow)
  );

  always #10 clk = ~clk;

  // every-clock comparison: the pull-down must hold steady across SCL high (R1)
  always @(posedge clk) begin
    if (rstN && scl && sclPrevM && sdaPullLow != pullPrevM) glitches++;
    sclPrevM <= scl; pullPrevM <= sdaPullLow;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startC();
    tick(Q); mSda = 1'b1; tick(Q); scl = 1'b1; tick(Q); mSda = 1'b0; tick(Q); scl = 1'b0;
    for (int i = 0; i < 8; i++) pendV[i] = 1'b0;
  endtask

  task automatic stopC(input bit wpAtStop);
    tick(Q); mSda = 1'b0; tick(Q); scl = 1'b1; tick(Q); mSda = 1'b1; tick(Q);
    for (int i = 0; i < 8; i++) begin
      if (pendV[i] && !wpAtStop) modelMem[(modelPtr & 8'hF8) | i] = pend[i];
      pendV[i] = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); mSda = b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0;
    end
    tick(Q); mSda = 1'b1; tick(Q); scl = 1'b1; tick(Q); acked = !sdaBus; tick(Q); scl = 1'b0;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); mSda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b[i] = sdaBus; tick(Q); scl = 1'b0;
    end
    tick(Q); mSda = !ackIt; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0;
  endtask

  task automatic writeBurst(input logic [7:0] addr, input bit wpVal, input bit waitBusy);
    bit a;
    wp = wpVal;
    startC();
    sendByte(DEVW, a); check(a, "R4 device ack", a, 1);
    sendByte(addr, a); check(a, "R4 word address ack", a, 1);
    modelPtr = addr;
    foreach (wq[k]) begin
      sendByte(wq[k], a); check(a, "R4 data ack", a, 1);
      pend[modelPtr & 7] = wq[k]; pendV[modelPtr & 7] = 1'b1;
      modelPtr = (modelPtr & 8'hF8) | ((modelPtr + 1) & 7);
    end
    stopC(wpVal);
    wp = 1'b0;
    if (waitBusy) tick(BUSY + 100);
  endtask

  task automatic readSeq(input bit random, input logic [7:0] addr, input int n, input string tag);
    bit a; logic [7:0] b;
    startC();
    if (random) begin
      sendByte(DEVW, a); check(a, {tag, " setup ack"}, a, 1);
      sendByte(addr, a); check(a, {tag, " address ack"}, a, 1);
      modelPtr = addr;
      startC();
    end
    sendByte(DEVR, a); check(a, {tag, " read address ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      check(b == modelMem[modelPtr], tag, b, modelMem[modelPtr]);
      modelPtr = (modelPtr + 1) & 8'hFF;
    end
    // one extra clock after the missing acknowledge: bus must stay high (R12)
    tick(Q); mSda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    check(sdaBus == 1'b1, "R12 released after nack", sdaBus, 1);
    tick(Q); scl = 1'b0;
    stopC(1'b0);
  endtask

  task automatic poll(input bit expAck, input string tag);
    bit a;
    startC(); sendByte(DEVW, a); check(a == expAck, tag, a, expAck); stopC(1'b0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    bit a; logic [7:0] b;
    for (int i = 0; i < 256; i++) modelMem[i] = 8'h00;
    for (int i = 0; i < 8; i++) begin pendV[i] = 1'b0; pend[i] = 8'h00; end
    tick(3);
    check(sdaPullLow == 1'b0, "R1 released in reset", sdaPullLow, 0);
    rstN = 1'b1;
    tick(5);
    check(sdaPullLow == 1'b0, "R1 released after reset", sdaPullLow, 0);

    // R3: wrong type code and wrong strap bits are ignored
    startC(); sendByte(8'hBA, a); check(!a, "R3 wrong type no ack", a, 0); stopC(1'b0);
    startC(); sendByte({4'b1010, 3'b011, 1'b0}, a); check(!a, "R3 wrong strap no ack", a, 0); stopC(1'b0);

    // R2/R4 byte write, then R8 busy polling
    wq = {8'hA5};
    writeBurst(8'h10, 1'b0, 1'b0);
    poll(1'b0, "R8 busy no ack");
    tick(BUSY + 100);
    poll(1'b1, "R8 ack after busy");

    // R9 random read
    readSeq(1'b1, 8'h10, 1, "R9 random read");

    // R5 page wrap with partial page, R11 current address after write
    wq = {8'h11, 8'h22, 8'h33};
    writeBurst(8'h1E, 1'b0, 1'b1);
    readSeq(1'b0, 8'h00, 1, "R11 current after write");
    readSeq(1'b1, 8'h18, 8, "R5 page wrap");

    // R5 more than a page: first bytes overwritten
    wq = {};
    for (int k = 0; k < 10; k++) wq.push_back(8'h40 + 8'(k));
    writeBurst(8'h20, 1'b0, 1'b1);
    readSeq(1'b1, 8'h20, 8, "R5 overflow overwrite");

    // R7 write protect: nothing stored, no busy
    wq = {8'h77};
    writeBurst(8'h10, 1'b1, 1'b0);
    poll(1'b1, "R7 no busy when protected");
    readSeq(1'b1, 8'h10, 1, "R7 protected byte kept");

    // R6 repeated start discards pending data
    startC();
    sendByte(DEVW, a); check(a, "R6 setup ack", a, 1);
    sendByte(8'h30, a); check(a, "R6 address ack", a, 1);
    modelPtr = 8'h30;
    sendByte(8'h99, a); check(a, "R6 data ack", a, 1);
    pend[0] = 8'h99; pendV[0] = 1'b1; modelPtr = 8'h31;
    readSeq(1'b0, 8'h00, 1, "R6 read after repeated start");
    readSeq(1'b1, 8'h30, 1, "R6 discarded byte absent");

    // R10 rollover across the top, R11 current address after read
    wq = {8'h5A};
    writeBurst(8'hFF, 1'b0, 1'b1);
    readSeq(1'b1, 8'hFE, 3, "R10 rollover");
    readSeq(1'b0, 8'h00, 2, "R11 current after read");

    check(glitches == 0, "R1 pull-down stable while SCL high", glitches, 0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      summary();
    end
  end
endmodule